// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a three-level table tree held in ordinary memory. The address is cut into a 7-bit first-level index, a 6-bit second-level index, a 6-bit third-level index and a 13-bit byte offset, so each page covers 8 KB. First-level entries are 8 bytes wide and are read as two 32-bit words. Entries at the two lower levels are 4 bytes wide. At every level the two low bits of the entry give its kind. That kind decides whether the walk goes down one more level, ends on a page, or stops with a fault.

A requester waits for `req_ready` and then presents a virtual address, a supervisor flag, a write flag and the root pointer for one cycle. The walker makes one word read per step on a plain request/response port. When the walk ends it pulses `done` for one cycle, together with the physical address, the cache-inhibit flag and a 2-bit fault code. The walker handles one request at a time. It has no translation cache and never writes back to the tables.

Top module: `pt_walker`

## Requirements
- R1: The first read is the word at root + first-level index × 8, which holds the limit in bits 31:16 and the status in bits 15:0. If that word is a table entry that grants access, the second read is the word at root + index × 8 + 4, and that word is the full second-level table base.
- R2: If the first-level entry is valid, the third read is at second-level base + second-level index × 4.
- R3: If the second-level word has type 2 (table), the fourth read is at its bits 31:4 with four zero bits appended, plus third-level index × 4.
- R4: If the third-level word has type 1 (page) and the access is allowed, the result is fault 0, a physical address made of bits 31:13 of that word followed by virtual address bits 12:0, and cache_inhibit equal to bit 6 of that word.
- R5: A descriptor whose type bits 1:0 are 00 or 11 at any level ends the walk with fault code 1 (bus error), and no further reads are made.
- R6: A page-type entry (01) at the first or second level, or a table-type entry (10) at the third level, ends the walk with fault code 3 (format).
- R7: A write ends with fault code 2 (protection) when bit 2 (write-protect) is set in the first-level status, the second-level word or the page word. A read through the same entries gives no fault.
- R8: A user-mode request (req_super = 0) whose first-level status has bit 8 clear ends with fault code 2 after the first read. A supervisor request, or a user request with bit 8 set, goes on.
- R9: req_ready is low from the cycle after a request is accepted until the walk ends. A req_valid that arrives during a walk is ignored. done is high for exactly one cycle.
- R10: After reset, req_ready is 1, and done and mem_req are 0.
- R11: When the fault code is not 0, paddr is 0 and cache_inhibit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_super | input | 1 | 1 = supervisor access |
| req_write | input | 1 | 1 = write access |
| root_ptr | input | 32 | Byte address of the first-level table |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle pulse: the result is valid |
| paddr | output | 32 | Translated physical address |
| cache_inhibit | output | 1 | Page is marked not cacheable |
| fault | output | 2 | 0 none, 1 bus error, 2 protection, 3 format |

## Verification
Random table paths are built around random virtual addresses. Each level gets a mostly-valid type, along with random write-protect, supervisor and cache-inhibit bits and random high address bits in the table bases. Comparing the logged read addresses tells apart the index scaling at each level: ×8 with a +4 second word at the top, ×4 below, and the dropped low nibble at the third level. The fault code shows which level ended the walk and for which cause. Directed cases cover:
- a clean supervisor read;
- user access with the supervisor bit clear and with it set;
- a write-protect bit that only affects writes;
- requests that arrive while a walk is already running.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2,
    FLT_FORMAT  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACT_NEXT  = 2'd0,
    ACT_PAGE  = 2'd1,
    ACT_FAULT = 2'd2
  } act_e;

  localparam logic [1:0] DT_INVALID = 2'd0;
  localparam logic [1:0] DT_PAGE    = 2'd1;
  localparam logic [1:0] DT_TABLE   = 2'd2;

  localparam logic [1:0] STEP_L1HI = 2'd0;
  localparam logic [1:0] STEP_L1LO = 2'd1;
  localparam logic [1:0] STEP_L2   = 2'd2;
  localparam logic [1:0] STEP_L3   = 2'd3;

  localparam int BIT_WP      = 2;
  localparam int BIT_CI      = 6;
  localparam int BIT_SUPER   = 8;
  localparam int TBL_ADDR_LSB = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen import ptw_pkg::*; #(
  parameter int VA_W      = 32,
  parameter int AW        = 32,
  parameter int L1_BITS   = 7,
  parameter int L2_BITS   = 6,
  parameter int L3_BITS   = 6,
  parameter int PAGE_BITS = 13
) (
  input  logic [1:0]      step,
  input  logic [VA_W-1:0] vaddr,
  input  logic [AW-1:0]   root,
  input  logic [AW-1:0]   base,
  output logic [AW-1:0]   fetch_addr
);
  localparam int L3_LSB     = PAGE_BITS;
  localparam int L2_LSB     = PAGE_BITS + L3_BITS;
  localparam int L1_LSB     = L2_LSB + L2_BITS;
  localparam int LONG_SHIFT = 3;
  localparam int SHORT_SHIFT = 2;

  logic [AW-1:0] off1, off2, off3;

  assign off1 = AW'(vaddr[L1_LSB +: L1_BITS]) << LONG_SHIFT;
  assign off2 = AW'(vaddr[L2_LSB +: L2_BITS]) << SHORT_SHIFT;
  assign off3 = AW'(vaddr[L3_LSB +: L3_BITS]) << SHORT_SHIFT;

  always_comb begin
    case (step)
      STEP_L1HI: fetch_addr = root + off1;
      STEP_L1LO: fetch_addr = root + off1 + AW'(4);
      STEP_L2:   fetch_addr = base + off2;
      default:   fetch_addr = base + off3;
    endcase
  end
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode import ptw_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [1:0]    step,
  input  logic [31:0]   word,
  input  logic          super_mode,
  input  logic          is_write,
  input  logic          wp_acc,
  output act_e          act,
  output fault_e        flt,
  output logic [AW-1:0] next_base,
  output logic          wp_next
);
  logic [1:0] dt;
  assign dt = word[1:0];

  always_comb begin
    act       = ACT_FAULT;
    flt       = FLT_INVALID;
    next_base = '0;
    wp_next   = wp_acc;
    case (step)
      STEP_L1HI: begin
        wp_next = wp_acc | word[BIT_WP];
        if (dt == DT_TABLE) begin
          if (!super_mode && !word[BIT_SUPER]) flt = FLT_PROT;
          else begin act = ACT_NEXT; flt = FLT_NONE; end
        end else if (dt == DT_PAGE) flt = FLT_FORMAT;
      end
      STEP_L1LO: begin
        act       = ACT_NEXT;
        flt       = FLT_NONE;
        next_base = AW'(word);
      end
      STEP_L2: begin
        wp_next = wp_acc | word[BIT_WP];
        if (dt == DT_TABLE) begin
          act       = ACT_NEXT;
          flt       = FLT_NONE;
          next_base = AW'({word[31:TBL_ADDR_LSB], {TBL_ADDR_LSB{1'b0}}});
        end else if (dt == DT_PAGE) flt = FLT_FORMAT;
      end
      default: begin
        wp_next = wp_acc | word[BIT_WP];
        if (dt == DT_PAGE) begin
          if (is_write && (wp_acc || word[BIT_WP])) flt = FLT_PROT;
          else begin act = ACT_PAGE; flt = FLT_NONE; end
        end else if (dt == DT_TABLE) flt = FLT_FORMAT;
      end
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker import ptw_pkg::*; #(
  parameter int VA_W      = 32,
  parameter int AW        = 32,
  parameter int L1_BITS   = 7,
  parameter int L2_BITS   = 6,
  parameter int L3_BITS   = 6,
  parameter int PAGE_BITS = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_super,
  input  logic            req_write,
  input  logic [AW-1:0]   root_ptr,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            done,
  output logic [AW-1:0]   paddr,
  output logic            cache_inhibit,
  output logic [1:0]      fault
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e          state_q;
  logic [1:0]      step_q;
  logic [VA_W-1:0] va_q;
  logic [AW-1:0]   root_q;
  logic            sup_q, wr_q, wp_q;

  logic [1:0]      gen_step;
  logic [VA_W-1:0] gen_va;
  logic [AW-1:0]   gen_root;
  logic [AW-1:0]   gen_addr;
  act_e            dec_act;
  fault_e          dec_flt;
  logic [AW-1:0]   dec_base;
  logic            dec_wp;

  assign req_ready = (state_q == ST_IDLE);
  assign gen_step  = req_ready ? STEP_L1HI : step_q + 2'd1;
  assign gen_va    = req_ready ? req_vaddr : va_q;
  assign gen_root  = req_ready ? root_ptr : root_q;

  ptw_addr_gen #(
    .VA_W(VA_W), .AW(AW), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
    .L3_BITS(L3_BITS), .PAGE_BITS(PAGE_BITS)
  ) u_addr (
    .step(gen_step), .vaddr(gen_va), .root(gen_root),
    .base(dec_base), .fetch_addr(gen_addr)
  );

  ptw_decode #(.AW(AW)) u_dec (
    .step(step_q), .word(mem_rsp_data), .super_mode(sup_q),
    .is_write(wr_q), .wp_acc(wp_q), .act(dec_act), .flt(dec_flt),
    .next_base(dec_base), .wp_next(dec_wp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      step_q        <= STEP_L1HI;
      va_q          <= '0;
      root_q        <= '0;
      sup_q         <= 1'b0;
      wr_q          <= 1'b0;
      wp_q          <= 1'b0;
      mem_req       <= 1'b0;
      mem_addr      <= '0;
      done          <= 1'b0;
      paddr         <= '0;
      cache_inhibit <= 1'b0;
      fault         <= FLT_NONE;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            root_q   <= root_ptr;
            sup_q    <= req_super;
            wr_q     <= req_write;
            wp_q     <= 1'b0;
            step_q   <= STEP_L1HI;
            mem_req  <= 1'b1;
            mem_addr <= gen_addr;
            state_q  <= ST_WAIT;
          end
        end
        default: begin
          if (mem_rsp_valid) begin
            wp_q <= dec_wp;
            case (dec_act)
              ACT_NEXT: begin
                step_q   <= step_q + 2'd1;
                mem_req  <= 1'b1;
                mem_addr <= gen_addr;
              end
              ACT_PAGE: begin
                done          <= 1'b1;
                paddr         <= {mem_rsp_data[AW-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
                cache_inhibit <= mem_rsp_data[BIT_CI];
                fault         <= FLT_NONE;
                state_q       <= ST_IDLE;
              end
              default: begin
                done          <= 1'b1;
                paddr         <= '0;
                cache_inhibit <= 1'b0;
                fault         <= dec_flt;
                state_q       <= ST_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_read_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  a_r11_fault_clears_result: assert property (@(posedge clk) disable iff (rst)
    (done && fault != FLT_NONE) |-> (paddr == '0 && !cache_inhibit));
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FLT_NONE) |-> paddr[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_super = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] root_ptr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] paddr;
  logic        cache_inhibit;
  logic [1:0]  fault;

  always #4 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_super(req_super), .req_write(req_write),
    .root_ptr(root_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .paddr(paddr), .cache_inhibit(cache_inhibit), .fault(fault)
  );

  logic [31:0] mem [0:4095];
  logic [31:0] log_addr [0:7];
  int n_log = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_mem(input logic [31:0] a, input logic [31:0] v);
    mem[a[13:2]] = v;
  endtask

  // memory responder: latency 0..2 cycles after the request is seen
  initial begin
    forever begin
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
      if (mem_req) begin
        logic [31:0] a;
        int lat;
        a = mem_addr;
        if (n_log < 8) log_addr[n_log] = a;
        n_log++;
        lat = $urandom % 3;
        for (int k = 0; k < lat; k++) begin @(posedge clk); #1; end
        mem_rsp_data  = mem[a[13:2]];
        mem_rsp_valid = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                          input logic sup, input logic wr,
                          input logic [31:0] w1hi, input logic [31:0] w1lo,
                          input logic [31:0] w2, input logic [31:0] w3,
                          input bit poke);
    logic [31:0] ea [0:3];
    int en;
    logic [1:0] ef;
    logic [31:0] ep;
    logic eci;
    string ftag;
    int waitc;
    ea[0] = root + ({25'd0, va[31:25]} << 3);
    ea[1] = ea[0] + 32'd4;
    ea[2] = w1lo + ({26'd0, va[24:19]} << 2);
    ea[3] = {w2[31:4], 4'b0} + ({26'd0, va[18:13]} << 2);
    wr_mem(ea[0], w1hi);
    wr_mem(ea[1], w1lo);
    wr_mem(ea[2], w2);
    wr_mem(ea[3], w3);
    ep = '0; eci = 1'b0; en = 1;
    if (w1hi[1:0] == 2'b10) begin
      if (!sup && !w1hi[8]) begin ef = 2'd2; ftag = "R8"; end
      else begin
        en = 3;
        if (w2[1:0] == 2'b10) begin
          en = 4;
          if (w3[1:0] == 2'b01) begin
            if (wr && (w1hi[2] || w2[2] || w3[2])) begin ef = 2'd2; ftag = "R7"; end
            else begin
              ef = 2'd0; ftag = "R4";
              ep = {w3[31:13], va[12:0]}; eci = w3[6];
            end
          end else if (w3[1:0] == 2'b10) begin ef = 2'd3; ftag = "R6"; end
          else begin ef = 2'd1; ftag = "R5"; end
        end else if (w2[1:0] == 2'b01) begin ef = 2'd3; ftag = "R6"; end
        else begin ef = 2'd1; ftag = "R5"; end
      end
    end else if (w1hi[1:0] == 2'b01) begin ef = 2'd3; ftag = "R6"; end
    else begin ef = 2'd1; ftag = "R5"; end

    while (!req_ready) begin @(posedge clk); #1; end
    n_log = 0;
    req_vaddr = va; root_ptr = root; req_super = sup; req_write = wr;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R9 ready drops", {31'd0, req_ready}, 32'd0);
    waitc = 0;
    while (!done && waitc < 200) begin
      if (poke) begin
        req_valid = 1'b1;
        req_vaddr = $urandom;
        root_ptr  = $urandom;
      end
      @(posedge clk); #1;
      waitc++;
    end
    req_valid = 1'b0;
    if (!done) begin
      n_fail++;
      $display("FAIL R9 walk timeout: actual no done expected done");
      return;
    end
    chk({ftag, " fault"}, {30'd0, fault}, {30'd0, ef});
    chk("R11/R4 paddr", paddr, ep);
    chk("R11/R4 cache_inhibit", {31'd0, cache_inhibit}, {31'd0, eci});
    chk("R5/R9 read count", n_log, en);
    chk("R1 first-level upper word addr", log_addr[0], ea[0]);
    if (en >= 3) begin
      chk("R1 first-level lower word addr", log_addr[1], ea[1]);
      chk("R2 second-level addr", log_addr[2], ea[2]);
    end
    if (en >= 4) chk("R3 third-level addr", log_addr[3], ea[3]);
    @(posedge clk); #1;
    chk("R9 done single cycle", {31'd0, done}, 32'd0);
  endtask

  function automatic logic [1:0] rtype(input logic [1:0] good);
    if (($urandom % 5) != 0) return good;
    return 2'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd20250824));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R10 done after reset", {31'd0, done}, 32'd0);
    chk("R10 mem_req after reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;

    // directed: clean supervisor read, cache inhibited page
    run_walk(32'hFEF0_4123, 32'h0001_0000, 1'b1, 1'b0,
             32'h7FFF_FC0A, 32'h00FF_C400, 32'h00FF_C80A, 32'h6400_0049, 1'b0);
    // R8: user through supervisor-only entry, then allowed with bit 8 set
    run_walk(32'h0123_4567, 32'h0, 1'b0, 1'b0,
             32'h7FFF_FC0A, 32'h0000_0400, 32'h0000_080A, 32'h0000_2059, 1'b0);
    run_walk(32'h0123_4567, 32'h0, 1'b0, 1'b0,
             32'h7FFF_FD0A, 32'h0000_0400, 32'h0000_080A, 32'h0000_2019, 1'b0);
    // R7: write-protect only in second level affects writes only
    run_walk(32'h8000_2ABC, 32'h0, 1'b1, 1'b1,
             32'h0000_010A, 32'h0000_0400, 32'h0000_080E, 32'h1234_4009, 1'b0);
    run_walk(32'h8000_2ABC, 32'h0, 1'b1, 1'b0,
             32'h0000_010A, 32'h0000_0400, 32'h0000_080E, 32'h1234_4009, 1'b0);
    // R9: requests arriving mid-walk are ignored
    run_walk(32'h4444_8888, 32'h0, 1'b1, 1'b0,
             32'h0000_010A, 32'h0000_0400, 32'h0000_080A, 32'hABCD_E041, 1'b1);

    for (int v = 0; v < 300; v++) begin
      logic [31:0] w1hi, w1lo, w2, w3;
      w1hi = {16'($urandom), 7'h7E, 1'($urandom), 4'b0,
              1'($urandom), (($urandom % 6) == 0), rtype(2'b10)};
      w1lo = ($urandom & 32'hFFFF_C000) | 32'h400;
      w2   = ($urandom & 32'hFFFF_C000) | 32'h800 |
             {28'd0, 1'($urandom), (($urandom % 6) == 0), rtype(2'b10)};
      w3   = {$urandom} & 32'hFFFF_FFF0;
      w3   = w3 | {29'd0, (($urandom % 6) == 0), rtype(2'b01)};
      run_walk($urandom, $urandom & 32'hFFFF_C000, 1'($urandom), 1'($urandom),
               w1hi, w1lo, w2, w3, (v % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule